// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave

This block is the slave side of a two-wire serial memory. It sits on an I2C bus, oversampling SCL and SDA with its own system clock, and serves a 1 Kbyte array split into four banks of 256 bytes. The master opens each transaction with a START and a select byte. The block answers only when that byte carries the device code and the chip-enable polarity strapped on `chip_en_i`. Two such slaves can therefore share one bus.

A write sends the select byte, then one byte address within the chosen bank, then data bytes. The data lands in a staging buffer and is committed to the array only when a STOP ends the write. After that STOP the slave stays busy for a fixed time and ignores new select bytes. `mode_i` picks how the staging buffer maps incoming bytes: a 16-byte page with in-page wrap, or a run of 4 consecutive addresses. A read returns bytes from a byte counter that persists across transactions. Reads can follow an address byte (random read) or start directly from the counter (current-address read). The counter wraps within the selected bank. SDA is driven as an open-drain output enable.

Top module: `i2c_ee_slave`

## Requirements
- R1: A select byte is acknowledged only if bits [7:4] equal 1010 and bit 3 equals `chip_en_i`. Otherwise the slave acknowledges nothing and drives nothing until the next START.
- R2: In an accepted select byte, bits [2:1] pick the bank. Bit 0 = 1 requests a read and bit 0 = 0 a write.
- R3: After an accepted write select, the next byte is a byte address and is acknowledged. It loads the byte counter. Each later data byte is also acknowledged and does not change the counter.
- R4: After reset every location reads FFh and `sda_oe_o` is low.
- R5: With `mode_i` = 0 when the address byte arrives (page mode), data byte n (from 0) goes to byte ((A[3:0]+n) mod 16) of the 16-byte page holding address A. A later byte to the same slot replaces the earlier one.
- R6: With `mode_i` = 1 when the address byte arrives (run mode), data byte n goes to byte (A + (n mod 4)) mod 256 of the selected bank. A later byte to the same slot replaces the earlier one.
- R7: Staged bytes are written to the array only on a STOP that ends a write. A START before that STOP discards them.
- R8: For 200 system clocks (parameter) after a STOP that commits data, select bytes are not acknowledged. Afterwards they are.
- R9: A read returns the byte at {bank, counter}, MSB first, and increments the counter after each byte. The counter wraps from FFh to 00h within the same bank.
- R10: A read select with no address byte before it continues from the counter left by the last transaction.
- R11: When the master does not acknowledge a read byte, the slave releases SDA and stays silent until START or STOP.
- R12: Read results do not depend on `mode_i`.
- R13: SDA is driven low only in an acknowledge slot of an accepted byte or in a read data bit. It is never driven while SCL is high outside those slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the master |
| sda_i | input | 1 | Resolved level of the serial data line |
| chip_en_i | input | 1 | Strap compared with select bit 3 |
| mode_i | input | 1 | Write mapping: 0 page, 1 run of four |
| sda_oe_o | output | 1 | High pulls SDA low |

## Verification
Two functions can fall on the same incoming byte. In page mode, a write longer than a page starting mid-page makes one byte both wrap the slot index and replace a slot that is already filled. On a read that crosses FFh, the counter wrap and the fetch of the next byte happen together. The bench provokes the first with an 18-byte page write starting at offset Eh and the second with a multi-byte read from FCh. It judges both by comparing every returned byte against a behavioural model of the array and counter. A further case lands a select byte inside the busy window right after a commit STOP and expects it to be refused.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  localparam int BYTE_W = 8;
  localparam int BANK_W = 2;
  localparam int ADDR_W = BYTE_W + BANK_W;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_ADDR, ST_WR, ST_RD, ST_WAIT
  } ee_state_e;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_p  <= scl_sr[STAGES-1];
      sda_p  <= sda_sr[STAGES-1];
    end
  end

  assign scl_s      = scl_sr[STAGES-1];
  assign sda_o      = sda_sr[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  // data edges while clock stays high
  assign start_o    = scl_s & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] arr_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) arr_q[i] <= '1;
    end else if (we_i) begin
      arr_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = arr_q[raddr_i];
endmodule

// File: rtl/i2c_ee_wbuf.sv
module i2c_ee_wbuf #(
  parameter int SLOTS = 16,
  parameter int MULTI = 4,
  parameter int BUSY  = 200,
  parameter int AW    = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic [AW-1:0] arm_addr_i,
  input  logic          arm_page_i,
  input  logic          push_i,
  input  logic [7:0]    push_data_i,
  input  logic          go_i,
  output logic          has_data_o,
  output logic          busy_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [7:0]    wdata_o
);
  localparam int SW = $clog2(SLOTS);
  localparam int CW = $clog2(BUSY + 1);

  logic [7:0]       data_q [SLOTS];
  logic [SLOTS-1:0] valid_q;
  logic [AW-1:0]    base_q;
  logic             page_q;
  logic [SW-1:0]    n_q, slot;
  logic [CW-1:0]    busy_q;
  logic [SW:0]      idx_q;
  logic [SW-1:0]    idx_lo;

  assign slot = page_q ? base_q[SW-1:0] + n_q : (n_q & SW'(MULTI - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      page_q <= 1'b1;
      n_q    <= '0;
    end else if (arm_i) begin
      base_q <= arm_addr_i;
      page_q <= arm_page_i;
      n_q    <= '0;
    end else if (push_i) begin
      n_q <= n_q + 1'b1;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g]  <= '0;
        valid_q[g] <= 1'b0;
      end else if (arm_i) begin
        valid_q[g] <= 1'b0;
      end else if (push_i && slot == SW'(g)) begin
        data_q[g]  <= push_data_i;
        valid_q[g] <= 1'b1;
      end
    end
  end

  // commit walks one slot per cycle inside the busy window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
      idx_q  <= '0;
    end else if (go_i) begin
      busy_q <= CW'(BUSY);
      idx_q  <= '0;
    end else if (busy_q != '0) begin
      busy_q <= busy_q - 1'b1;
      if (!idx_q[SW]) idx_q <= idx_q + 1'b1;
    end
  end

  assign idx_lo     = idx_q[SW-1:0];
  assign has_data_o = |valid_q;
  assign busy_o     = busy_q != '0;
  assign we_o       = busy_o && !idx_q[SW] && valid_q[idx_lo];
  assign wdata_o    = data_q[idx_lo];
  assign waddr_o    = page_q ? {base_q[AW-1:SW], idx_lo}
                             : {base_q[AW-1:8], base_q[7:0] + 8'(idx_lo)};

  a_r7_no_arm_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |-> !busy_o);
endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave
  import i2c_ee_pkg::*;
#(
  parameter int PAGE_BYTES  = 16,
  parameter int MULTI_BYTES = 4,
  parameter int BUSY_CYCLES = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic chip_en_i,
  input  logic mode_i,
  output logic sda_oe_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, has_data, mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [BYTE_W-1:0] mem_wdata, rdata;

  ee_state_e         state_q;
  logic [3:0]        bit_cnt_q;
  logic [6:0]        shreg_q;
  logic              ack_drv_q, oe_q, rw_q;
  logic [BANK_W-1:0] bank_q;
  logic [BYTE_W-1:0] cnt_q, tx_q;
  logic [BYTE_W-1:0] byte_in;
  logic              active, byte_done, dev_hit, arm, push, go;

  i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign active    = state_q inside {ST_SEL, ST_ADDR, ST_WR, ST_RD};
  assign byte_in   = {shreg_q, sda_s};
  assign byte_done = active && !start_det && !stop_det && scl_rise && bit_cnt_q == 4'd7;
  assign dev_hit   = byte_in[7:4] == DEV_CODE && byte_in[3] == chip_en_i && !busy;
  assign arm       = byte_done && state_q == ST_ADDR;
  assign push      = byte_done && state_q == ST_WR;
  assign go        = stop_det && state_q == ST_WR && has_data;

  i2c_ee_wbuf #(
    .SLOTS(PAGE_BYTES), .MULTI(MULTI_BYTES), .BUSY(BUSY_CYCLES), .AW(ADDR_W)
  ) u_wbuf (
    .clk_i, .rst_ni,
    .arm_i(arm), .arm_addr_i({bank_q, byte_in}), .arm_page_i(~mode_i),
    .push_i(push), .push_data_i(byte_in), .go_i(go),
    .has_data_o(has_data), .busy_o(busy),
    .we_o(mem_we), .waddr_o(mem_waddr), .wdata_o(mem_wdata)
  );

  i2c_ee_mem #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
    .clk_i, .rst_ni,
    .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
    .raddr_i({bank_q, cnt_q}), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      ack_drv_q <= 1'b0;
      oe_q      <= 1'b0;
      rw_q      <= 1'b0;
      bank_q    <= '0;
      cnt_q     <= '0;
      tx_q      <= '1;
    end else if (start_det) begin
      state_q   <= ST_SEL;
      bit_cnt_q <= '0;
      ack_drv_q <= 1'b0;
      oe_q      <= 1'b0;
    end else if (stop_det) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (active && scl_rise) begin
      if (bit_cnt_q != 4'd8) begin
        shreg_q   <= byte_in[6:0];
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (bit_cnt_q == 4'd7) begin
          unique case (state_q)
            ST_SEL: begin
              ack_drv_q <= dev_hit;
              if (dev_hit) {bank_q, rw_q} <= byte_in[2:0];
            end
            ST_ADDR: begin
              cnt_q     <= byte_in;
              ack_drv_q <= 1'b1;
            end
            ST_WR: ack_drv_q <= 1'b1;
            ST_RD: begin
              ack_drv_q <= 1'b0;
              cnt_q     <= cnt_q + 1'b1;
            end
            default: ack_drv_q <= 1'b0;
          endcase
        end
      end else begin
        // acknowledge clock
        bit_cnt_q <= '0;
        unique case (state_q)
          ST_SEL: begin
            if (!ack_drv_q) state_q <= ST_IDLE;
            else if (rw_q) begin
              state_q <= ST_RD;
              tx_q    <= rdata;
            end else state_q <= ST_ADDR;
          end
          ST_ADDR: state_q <= ST_WR;
          ST_RD: begin
            if (sda_s) state_q <= ST_WAIT;
            else tx_q <= rdata;
          end
          default: state_q <= state_q;
        endcase
      end
    end else if (active && scl_fall) begin
      if (bit_cnt_q == 4'd8) oe_q <= ack_drv_q;
      else if (state_q == ST_RD) oe_q <= ~tx_q[3'd7 - bit_cnt_q[2:0]];
      else oe_q <= 1'b0;
    end
  end

  assign sda_oe_o = oe_q;

  a_r13_oe_when_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> state_q inside {ST_SEL, ST_ADDR, ST_WR, ST_RD});

  a_r8_no_ack_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEL && ack_drv_q) |-> !busy);

  a_r2_addr_only_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR) |-> !rw_q);

  a_r9_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && state_q == ST_RD) |=> cnt_q == $past(cnt_q) + 8'd1);
endmodule

// File: tb/i2c_ee_slave_bench.sv
module i2c_ee_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 8;
  localparam int BUSY       = 200;
  localparam int MULTI      = 4;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic chip_en = 1'b1, mode = 1'b0;
  logic sda_oe, sda_bus;
  int   model [1024];
  int   cnt_m = 0;
  int   checks = 0, fails = 0, viol = 0;
  bit   slave_turn = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_ee_slave #(.BUSY_CYCLES(BUSY)) u_i2c_ee_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .chip_en_i(chip_en), .mode_i(mode), .sda_oe_o(sda_oe)
  );

  // R13: per-clock bus discipline against the model of whose turn it is
  always begin
    @(posedge clk);
    #2;
    if (rst_n && scl && !slave_turn && sda_oe) viol++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  function automatic int sel(input int bank, input int rw, input int ce);
    return 'hA0 | (ce << 3) | (bank << 1) | rw;
  endfunction

  task automatic i2c_start();
    slave_turn = 1'b0;
    sda_m = 1'b1; tick(H);
    scl = 1'b1;   tick(H);
    sda_m = 1'b0; tick(H);
    scl = 1'b0;
  endtask

  task automatic i2c_stop();
    slave_turn = 1'b0;
    sda_m = 1'b0; tick(H);
    scl = 1'b1;   tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic wbit(input bit v);
    slave_turn = 1'b0;
    sda_m = v; tick(H);
    scl = 1'b1; tick(H);
    scl = 1'b0;
  endtask

  task automatic rbit(output bit v);
    slave_turn = 1'b1;
    sda_m = 1'b1; tick(H);
    scl = 1'b1;   tick(H / 2);
    v = sda_bus;  tick(H / 2);
    scl = 1'b0;
  endtask

  task automatic send_byte(input int b, output bit ack);
    bit x;
    for (int i = 7; i >= 0; i--) wbit(bit'((b >> i) & 1));
    rbit(x);
    ack = !x;
  endtask

  task automatic recv_byte(output int b, input bit ack);
    bit x;
    b = 0;
    for (int i = 0; i < 8; i++) begin
      rbit(x);
      b = (b << 1) | int'(x);
    end
    wbit(!ack);
  endtask

  task automatic write_txn(input int bank, input int addr, input int num, input int seed,
                           input bit page, input bit wait_busy);
    bit ack;
    int d, a;
    mode = !page;
    i2c_start();
    send_byte(sel(bank, 0, 1), ack);
    check(ack, "R1", ack, 1);
    send_byte(addr, ack);
    check(ack, "R3", ack, 1);
    for (int i = 0; i < num; i++) begin
      d = (seed + 37 * i) & 255;
      send_byte(d, ack);
      check(ack, "R3", ack, 1);
      if (page) a = bank * 256 + (addr & 'hF0) + ((addr + i) & 15);
      else a = bank * 256 + ((addr + (i % MULTI)) & 255);
      model[a] = d;
    end
    i2c_stop();
    cnt_m = addr;
    if (wait_busy) tick(BUSY + 60);
  endtask

  task automatic read_seq(input int bank, input int addr, input int num, input string req);
    bit ack;
    int b, e;
    i2c_start();
    if (addr >= 0) begin
      send_byte(sel(bank, 0, 1), ack);
      check(ack, "R3", ack, 1);
      send_byte(addr, ack);
      check(ack, "R3", ack, 1);
      cnt_m = addr;
      i2c_start();
    end
    send_byte(sel(bank, 1, 1), ack);
    check(ack, "R2", ack, 1);
    for (int i = 0; i < num; i++) begin
      recv_byte(b, i != num - 1);
      e = model[bank * 256 + cnt_m];
      check(b == e, req, b, e);
      cnt_m = (cnt_m + 1) & 255;
    end
    i2c_stop();
  endtask

  initial begin
    bit ack, x;
    int b, all1;
    for (int i = 0; i < 1024; i++) model[i] = 255;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    check(sda_oe == 1'b0, "R4", sda_oe, 0);

    // R4 R9: erased contents, sequential
    read_seq(0, 'h05, 2, "R4");

    // R1: wrong device code, wrong chip-enable, then no ack for a later byte
    i2c_start();
    send_byte('hB0, ack);
    check(!ack, "R1", ack, 0);
    send_byte('h00, ack);
    check(!ack, "R1", ack, 0);
    i2c_stop();
    i2c_start();
    send_byte(sel(0, 1, 0), ack);
    check(!ack, "R1", ack, 0);
    i2c_stop();

    // R5 R7 R2: small page write, readback straddling it
    write_txn(1, 'h13, 3, 'h11, 1'b1, 1'b1);
    read_seq(1, 'h12, 5, "R5");

    // R5: page wrap and slot overwrite on the same write
    write_txn(1, 'h2E, 18, 'h40, 1'b1, 1'b1);
    read_seq(1, 'h20, 16, "R5");

    // R6: run mode across bank end; R9 wrap on read, R12 mode high
    write_txn(2, 'hFE, 6, 'h90, 1'b0, 1'b1);
    mode = 1'b1;
    read_seq(2, 'hFC, 8, "R6");

    // R10: current-address reads, same bank then another bank
    read_seq(2, -1, 2, "R10");
    read_seq(1, -1, 1, "R10");

    // R12: same location with mode low and high
    mode = 1'b0;
    read_seq(2, 'hFF, 1, "R12");
    mode = 1'b1;
    read_seq(2, 'hFF, 1, "R12");

    // R8: select during busy refused, accepted later
    write_txn(3, 'h40, 1, 'h5A, 1'b1, 1'b0);
    i2c_start();
    send_byte(sel(3, 1, 1), ack);
    check(!ack, "R8", ack, 0);
    i2c_stop();
    tick(BUSY + 60);
    read_seq(3, 'h40, 1, "R8");

    // R7: repeated START discards staged data
    mode = 1'b0;
    i2c_start();
    send_byte(sel(0, 0, 1), ack);
    send_byte('h80, ack);
    send_byte('h12, ack);
    send_byte('h34, ack);
    cnt_m = 'h80;
    i2c_start();
    send_byte(sel(0, 1, 1), ack);
    recv_byte(b, 1'b0);
    check(b == 255, "R7", b, 255);
    i2c_stop();
    tick(BUSY + 60);
    read_seq(0, 'h80, 2, "R7");

    // R11: after master NACK the line stays released
    i2c_start();
    send_byte(sel(1, 1, 1), ack);
    recv_byte(b, 1'b0);
    all1 = 1;
    for (int i = 0; i < 9; i++) begin
      rbit(x);
      if (!x) all1 = 0;
    end
    check(all1 == 1, "R11", all1, 1);
    i2c_stop();
    cnt_m = (cnt_m + 1) & 255;

    tick(20);
    check(viol == 0, "R13", viol, 0);
    summary();
  end
endmodule